// File: doc/BRIEF.md
# Two-Point ADC Calibration Controller

This block runs the power-up calibration of a housekeeping ADC. On a start pulse it asks an external conversion sequencer for four conversions, one after another. The first two measure two fixed reference channels and give the absolute gain and offset. The last two measure the mux-off channel with the ratiometric reference forced to two different settings. From each pair it derives a signed slope delta and a ground code, and it keeps them in registers for the rest of the system.

Each conversion is requested over a simple level handshake. The controller raises `req_o` with a channel number, a force flag and a reference setting. The sequencer answers with a single-cycle `ack_i` that carries the result code and a timeout flag. A timed-out conversion aborts the run. An absolute pair whose two codes are equal also aborts the run, and in that case no ratiometric conversion is requested. The calibration registers change only when all four conversions succeed.

Top module: `adcal_ctrl`

## Requirements
- R1: After reset, `req_o`, `busy_o`, `done_o`, `err_o` and `cal_valid_o` are 0 and all four calibration outputs are 0.
- R2: A run issues its requests in a fixed order. The first is channel 0x0D and the second is channel 0x0C, both with `req_force_o`=0 and `req_ref_o`=0. The third is channel 0x0F with `req_force_o`=1 and `req_ref_o`=5. The fourth is channel 0x0F with `req_force_o`=1 and `req_ref_o`=4.
- R3: After a successful run, `abs_delta_o` is the 17-bit signed difference code(0x0D) minus code(0x0C), and `abs_gnd_o` is code(0x0C).
- R4: After a successful run, `rat_delta_o` is the 17-bit signed difference code(ref 5) minus code(ref 4), and `rat_gnd_o` is code(ref 4).
- R5: If the two absolute codes are equal, the run ends with `err_o`=1 and a `done_o` pulse. No further request is issued, and all calibration outputs keep their previous values.
- R6: An acknowledge with `res_timeout_i`=1 on any of the four conversions ends the run at once with `err_o`=1 and a `done_o` pulse. No further request is issued, and the calibration outputs keep their previous values.
- R7: `cal_valid_o` is cleared in the cycle after an accepted start. It is set, together with a `done_o` pulse and `err_o`=0, only when all four conversions have succeeded.
- R8: A start pulse while `busy_o`=1 is ignored. The run in progress continues with its next step.
- R9: While `req_o` is high and no acknowledge has arrived, the request fields stay stable. `req_o` is low for at least one cycle after every acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration run (accepted only when idle) |
| req_o | output | 1 | Conversion request to the sequencer |
| req_chan_o | output | 4 | Analog mux channel of the request |
| req_force_o | output | 1 | 1: use `req_ref_o` instead of the channel's own reference |
| req_ref_o | output | 3 | Forced reference setting, 0 when not forced |
| ack_i | input | 1 | Single-cycle conversion completion |
| res_code_i | input | 16 | Result code, valid with `ack_i` |
| res_timeout_i | input | 1 | Conversion timed out, valid with `ack_i` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Single-cycle pulse at the end of a run |
| err_o | output | 1 | Last run failed, held until the next start |
| cal_valid_o | output | 1 | Calibration registers hold a complete result |
| abs_delta_o | output | 17 | Signed absolute slope delta |
| abs_gnd_o | output | 16 | Absolute ground code |
| rat_delta_o | output | 17 | Signed ratiometric slope delta |
| rat_gnd_o | output | 16 | Ratiometric ground code |

## Verification
The bench gives the lower reference a larger code than the upper one, and also the full-scale pair 0xFFFF and 0. A design that keeps only 16 bits of the difference, or subtracts the codes in the wrong order, shows a wrong sign or a wrapped value. Failures are injected at the first and the last conversion, and an equal absolute pair is applied. A design that overwrites the stored results, raises `cal_valid_o`, or goes on to the ratiometric channel would show changed outputs or a stray request. A start pulse in mid-run checks that the controller does not restart at channel 0x0D.

// File: rtl/adcal_pkg.sv
package adcal_pkg;
   localparam int NSTEP      = 4;
   localparam int IDX_ABS_HI = 0;
   localparam int IDX_ABS_LO = 1;
   localparam int IDX_RAT_HI = 2;
   localparam int IDX_RAT_LO = 3;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_REQ    = 2'd1,
      ST_GAP    = 2'd2,
      ST_COMMIT = 2'd3
   } cal_state_t;
endpackage

// File: rtl/adcal_step_sel.sv
module adcal_step_sel #(
   parameter int CHAN_W = 4,
   parameter int REF_W  = 3,
   parameter int STEP_W = 2,
   parameter int CH_HI  = 13,
   parameter int CH_LO  = 12,
   parameter int CH_OFF = 15,
   parameter int REF_HI = 5,
   parameter int REF_LO = 4
) (
   input  logic [STEP_W-1:0] step_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic              force_o,
   output logic [REF_W-1:0]  ref_o
);
   import adcal_pkg::*;

   always_comb begin
      chan_o  = CHAN_W'(CH_HI);
      force_o = 1'b0;
      ref_o   = '0;
      case (int'(step_i))
         IDX_ABS_HI: chan_o = CHAN_W'(CH_HI);
         IDX_ABS_LO: chan_o = CHAN_W'(CH_LO);
         IDX_RAT_HI: begin
            chan_o  = CHAN_W'(CH_OFF);
            force_o = 1'b1;
            ref_o   = REF_W'(REF_HI);
         end
         IDX_RAT_LO: begin
            chan_o  = CHAN_W'(CH_OFF);
            force_o = 1'b1;
            ref_o   = REF_W'(REF_LO);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/adcal_seq.sv
module adcal_seq #(
   parameter int CODE_W = 16,
   parameter int STEP_W = 2
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    start_i,
   input  logic                                    ack_i,
   input  logic [CODE_W-1:0]                       code_i,
   input  logic                                    timeout_i,
   output logic                                    req_o,
   output logic [STEP_W-1:0]                       step_o,
   output logic                                    busy_o,
   output logic                                    done_o,
   output logic                                    err_o,
   output logic                                    launch_o,
   output logic                                    commit_o,
   output logic [adcal_pkg::NSTEP-1:0][CODE_W-1:0] caps_o
);
   import adcal_pkg::*;

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);
   localparam logic [STEP_W-1:0] DEGEN_AT  = STEP_W'(IDX_ABS_LO);

   cal_state_t        state;
   logic [STEP_W-1:0] step;
   logic              take;
   logic              degen;

   assign take     = (state == ST_REQ) && ack_i;
   assign degen    = (step == DEGEN_AT) && (code_i == caps_o[IDX_ABS_HI]);
   assign req_o    = (state == ST_REQ);
   assign busy_o   = (state != ST_IDLE);
   assign launch_o = (state == ST_IDLE) && start_i;
   assign commit_o = (state == ST_COMMIT);
   assign step_o   = step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         step   <= '0;
         err_o  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            ST_IDLE: if (start_i) begin
               state <= ST_REQ;
               step  <= '0;
               err_o <= 1'b0;
            end
            ST_REQ: if (ack_i) begin
               if (timeout_i || degen) begin
                  state  <= ST_IDLE;
                  err_o  <= 1'b1;
                  done_o <= 1'b1;
               end else if (step == LAST_STEP) begin
                  state <= ST_COMMIT;
               end else begin
                  state <= ST_GAP;
                  step  <= step + 1'b1;
               end
            end
            ST_GAP:    state <= ST_REQ;
            ST_COMMIT: begin
               state  <= ST_IDLE;
               done_o <= 1'b1;
            end
            default:   state <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NSTEP; g++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            caps_o[g] <= '0;
         else if (take && !timeout_i && (step == STEP_W'(g)))
            caps_o[g] <= code_i;
      end
   end

   // R6: a timed-out conversion returns the controller to idle with an error
   a_r6_timeout_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (take && timeout_i) |=> (state == ST_IDLE && err_o && done_o));

   // R5: an equal absolute pair never reaches the ratiometric steps
   a_r5_degen_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !timeout_i && step == DEGEN_AT && code_i == caps_o[IDX_ABS_HI])
      |=> (state == ST_IDLE && err_o));

   // R8: a start pulse in the gap does not rewind the step counter
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP && start_i) |=> (state == ST_REQ && $stable(step)));
endmodule

// File: rtl/adcal_commit.sv
module adcal_commit #(
   parameter int CODE_W  = 16,
   parameter int DELTA_W = CODE_W + 1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    launch_i,
   input  logic                                    commit_i,
   input  logic [adcal_pkg::NSTEP-1:0][CODE_W-1:0] caps_i,
   output logic                                    valid_o,
   output logic signed [DELTA_W-1:0]               abs_delta_o,
   output logic [CODE_W-1:0]                       abs_gnd_o,
   output logic signed [DELTA_W-1:0]               rat_delta_o,
   output logic [CODE_W-1:0]                       rat_gnd_o
);
   import adcal_pkg::*;

   logic signed [DELTA_W-1:0] abs_diff;
   logic signed [DELTA_W-1:0] rat_diff;

   assign abs_diff = $signed({1'b0, caps_i[IDX_ABS_HI]}) - $signed({1'b0, caps_i[IDX_ABS_LO]});
   assign rat_diff = $signed({1'b0, caps_i[IDX_RAT_HI]}) - $signed({1'b0, caps_i[IDX_RAT_LO]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o     <= 1'b0;
         abs_delta_o <= '0;
         abs_gnd_o   <= '0;
         rat_delta_o <= '0;
         rat_gnd_o   <= '0;
      end else if (commit_i) begin
         valid_o     <= 1'b1;
         abs_delta_o <= abs_diff;
         abs_gnd_o   <= caps_i[IDX_ABS_LO];
         rat_delta_o <= rat_diff;
         rat_gnd_o   <= caps_i[IDX_RAT_LO];
      end else if (launch_i) begin
         valid_o <= 1'b0;
      end
   end

   // R7: a new start withdraws the previous result
   a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |=> !valid_o);

   // R3, R4: stored results change only on a commit
   a_r3_hold_abs: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> ($stable(abs_delta_o) && $stable(abs_gnd_o)));
   a_r4_hold_rat: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> ($stable(rat_delta_o) && $stable(rat_gnd_o)));
endmodule

// File: rtl/adcal_ctrl.sv
module adcal_ctrl #(
   parameter int CODE_W  = 16,
   parameter int CHAN_W  = 4,
   parameter int REF_W   = 3,
   parameter int CH_HI   = 13,
   parameter int CH_LO   = 12,
   parameter int CH_OFF  = 15,
   parameter int REF_HI  = 5,
   parameter int REF_LO  = 4,
   parameter int DELTA_W = CODE_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   output logic                      req_o,
   output logic [CHAN_W-1:0]         req_chan_o,
   output logic                      req_force_o,
   output logic [REF_W-1:0]          req_ref_o,
   input  logic                      ack_i,
   input  logic [CODE_W-1:0]         res_code_i,
   input  logic                      res_timeout_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic                      err_o,
   output logic                      cal_valid_o,
   output logic signed [DELTA_W-1:0] abs_delta_o,
   output logic [CODE_W-1:0]         abs_gnd_o,
   output logic signed [DELTA_W-1:0] rat_delta_o,
   output logic [CODE_W-1:0]         rat_gnd_o
);
   import adcal_pkg::*;

   localparam int STEP_W = $clog2(NSTEP);

   initial begin
      assert (CODE_W >= 2) else $fatal(1, "CODE_W too small");
      assert (DELTA_W == CODE_W + 1) else $fatal(1, "DELTA_W must be CODE_W+1");
      assert (CH_HI < (1 << CHAN_W) && CH_LO < (1 << CHAN_W) && CH_OFF < (1 << CHAN_W))
         else $fatal(1, "channel does not fit CHAN_W");
      assert (REF_HI < (1 << REF_W) && REF_LO < (1 << REF_W)) else $fatal(1, "reference does not fit REF_W");
      assert (CH_HI != CH_LO && REF_HI != REF_LO) else $fatal(1, "reference pair collapses");
   end

   logic [STEP_W-1:0]                  step;
   logic                               launch;
   logic                               commit;
   logic [NSTEP-1:0][CODE_W-1:0]       caps;

   adcal_seq #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .ack_i    (ack_i),
      .code_i   (res_code_i),
      .timeout_i(res_timeout_i),
      .req_o    (req_o),
      .step_o   (step),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .err_o    (err_o),
      .launch_o (launch),
      .commit_o (commit),
      .caps_o   (caps)
   );

   adcal_step_sel #(
      .CHAN_W(CHAN_W), .REF_W(REF_W), .STEP_W(STEP_W),
      .CH_HI(CH_HI), .CH_LO(CH_LO), .CH_OFF(CH_OFF),
      .REF_HI(REF_HI), .REF_LO(REF_LO)
   ) u_sel (
      .step_i (step),
      .chan_o (req_chan_o),
      .force_o(req_force_o),
      .ref_o  (req_ref_o)
   );

   adcal_commit #(.CODE_W(CODE_W), .DELTA_W(DELTA_W)) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch),
      .commit_i   (commit),
      .caps_i     (caps),
      .valid_o    (cal_valid_o),
      .abs_delta_o(abs_delta_o),
      .abs_gnd_o  (abs_gnd_o),
      .rat_delta_o(rat_delta_o),
      .rat_gnd_o  (rat_gnd_o)
   );

   // R9: request fields stay put until acknowledged
   a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> (req_o && $stable(req_chan_o) && $stable(req_force_o) && $stable(req_ref_o)));

   // R9: a dead cycle follows every acknowledge
   a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i) |=> !req_o);

   // R7: the valid flag rises only with a clean completion
   a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_valid_o) |-> (done_o && !err_o));

   // R2: ratiometric requests always carry a forced reference on the mux-off channel
   a_r2_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && req_force_o) |-> (req_chan_o == CHAN_W'(CH_OFF)));
endmodule

// File: tb/adcal_ctrl_tb.sv
module adcal_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        req_o;
   logic [3:0]  req_chan_o;
   logic        req_force_o;
   logic [2:0]  req_ref_o;
   logic        ack_i = 1'b0;
   logic [15:0] res_code_i = '0;
   logic        res_timeout_i = 1'b0;
   logic        busy_o, done_o, err_o, cal_valid_o;
   logic signed [16:0] abs_delta_o, rat_delta_o;
   logic [15:0] abs_gnd_o, rat_gnd_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic signed [16:0] m_abs_d = '0, m_rat_d = '0;
   logic [15:0]        m_abs_g = '0, m_rat_g = '0;

   always #2.5 clk = ~clk;

   adcal_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .req_o(req_o), .req_chan_o(req_chan_o), .req_force_o(req_force_o), .req_ref_o(req_ref_o),
      .ack_i(ack_i), .res_code_i(res_code_i), .res_timeout_i(res_timeout_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .cal_valid_o(cal_valid_o),
      .abs_delta_o(abs_delta_o), .abs_gnd_o(abs_gnd_o),
      .rat_delta_o(rat_delta_o), .rat_gnd_o(rat_gnd_o)
   );

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   // act as the sequencer for one conversion, checking the request fields
   task automatic serve(int step, logic [15:0] code, bit tmo, bit start_mid);
      int exp_chan, exp_ref;
      bit exp_force;
      int waited = 0;
      exp_chan  = (step == 0) ? 13 : (step == 1) ? 12 : 15;
      exp_force = (step >= 2);
      exp_ref   = (step == 2) ? 5 : (step == 3) ? 4 : 0;
      while (!req_o && waited < 20) begin
         @(negedge clk); waited++;
      end
      chk(req_o == 1'b1, "R2 request raised", req_o, 1);
      chk(req_chan_o == 4'(exp_chan), "R2 channel", req_chan_o, exp_chan);
      chk(req_force_o == exp_force, "R2 force flag", req_force_o, exp_force);
      chk(req_ref_o == 3'(exp_ref), "R2 reference", req_ref_o, exp_ref);
      if (!req_o) return;
      @(negedge clk);
      chk(req_chan_o == 4'(exp_chan), "R9 field held before ack", req_chan_o, exp_chan);
      ack_i = 1'b1; res_code_i = code; res_timeout_i = tmo;
      if (start_mid) start_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0; res_timeout_i = 1'b0; res_code_i = '0;
      chk(req_o == 1'b0, "R9 gap after ack", req_o, 0);
      if (start_mid) begin
         @(negedge clk); start_i = 1'b0;
      end
   endtask

   task automatic wait_done();
      int waited = 0;
      while (!done_o && waited < 20) begin
         @(negedge clk); waited++;
      end
      chk(done_o == 1'b1, "done pulse seen", done_o, 1);
   endtask

   task automatic check_held(string tag);
      chk(abs_delta_o == m_abs_d, {tag, " abs delta held"}, abs_delta_o, m_abs_d);
      chk(abs_gnd_o == m_abs_g, {tag, " abs gnd held"}, abs_gnd_o, m_abs_g);
      chk(rat_delta_o == m_rat_d, {tag, " rat delta held"}, rat_delta_o, m_rat_d);
      chk(rat_gnd_o == m_rat_g, {tag, " rat gnd held"}, rat_gnd_o, m_rat_g);
   endtask

   task automatic quiet_after(string tag);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(req_o == 1'b0, {tag, " no further request"}, req_o, 0);
      end
   endtask

   task automatic t_reset();
      chk(req_o == 0 && busy_o == 0 && done_o == 0, "R1 control idle", {req_o, busy_o, done_o}, 0);
      chk(err_o == 0 && cal_valid_o == 0, "R1 status clear", {err_o, cal_valid_o}, 0);
      check_held("R1");
   endtask

   task automatic t_success(logic [15:0] c0, c1, c2, c3, bit mid_start);
      pulse_start();
      chk(cal_valid_o == 1'b0, "R7 valid cleared by start", cal_valid_o, 0);
      chk(busy_o == 1'b1, "busy after start", busy_o, 1);
      serve(0, c0, 0, mid_start);
      serve(1, c1, 0, 0);
      serve(2, c2, 0, mid_start);
      serve(3, c3, 0, 0);
      wait_done();
      m_abs_d = $signed({1'b0, c0}) - $signed({1'b0, c1});
      m_abs_g = c1;
      m_rat_d = $signed({1'b0, c2}) - $signed({1'b0, c3});
      m_rat_g = c3;
      chk(err_o == 1'b0, "R7 no error", err_o, 0);
      chk(cal_valid_o == 1'b1, "R7 valid after four", cal_valid_o, 1);
      chk(abs_delta_o == m_abs_d, "R3 abs delta", abs_delta_o, m_abs_d);
      chk(abs_gnd_o == m_abs_g, "R3 abs gnd", abs_gnd_o, m_abs_g);
      chk(rat_delta_o == m_rat_d, "R4 rat delta", rat_delta_o, m_rat_d);
      chk(rat_gnd_o == m_rat_g, "R4 rat gnd", rat_gnd_o, m_rat_g);
      @(negedge clk);
      chk(done_o == 1'b0 && busy_o == 1'b0, "done is a single pulse", done_o, 0);
   endtask

   task automatic t_degenerate();
      pulse_start();
      serve(0, 16'h1234, 0, 0);
      serve(1, 16'h1234, 0, 0);
      wait_done();
      chk(err_o == 1'b1, "R5 error on equal pair", err_o, 1);
      chk(cal_valid_o == 1'b0, "R5 valid stays low", cal_valid_o, 0);
      check_held("R5");
      quiet_after("R5");
   endtask

   task automatic t_timeout(int at_step);
      pulse_start();
      for (int s = 0; s < at_step; s++) serve(s, 16'(16'h0400 + s * 16'h0111), 0, 0);
      serve(at_step, 16'h0999, 1, 0);
      wait_done();
      chk(err_o == 1'b1, "R6 error on timeout", err_o, 1);
      chk(cal_valid_o == 1'b0, "R6 valid stays low", cal_valid_o, 0);
      check_held("R6");
      quiet_after("R6");
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_success(16'h8000, 16'h4000, 16'h7000, 16'h0100, 0);
      t_success(16'h0100, 16'h8000, 16'h0010, 16'h0020, 0);   // negative deltas
      t_success(16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 0);   // full-scale, 17-bit range
      t_degenerate();
      t_timeout(0);
      t_timeout(3);
      t_success(16'h2222, 16'h1111, 16'h3333, 16'h0003, 1);   // R8 start ignored while busy
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule